// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a processor core and keeps track of up to 256 interrupt vectors in three bitmaps: vectors waiting for service, vectors currently being serviced, and the trigger kind (level or edge) recorded for each vector. A source delivers a vector through a one-cycle request port. The controller works out which pending vector has the highest priority and offers it to the core. When the core acknowledges, that vector moves from pending to in service. When the core issues an end-of-interrupt, the controller retires the highest in-service vector and reports its number and trigger kind, so that a level-triggered source can be re-armed.

Priority is compared by class, which is the upper four bits of the vector number. A task priority value written by software sets a floor. The effective processor priority is derived from that floor and from the class of the highest vector in service. A pending vector is offered only when its class, with the low bits cleared, is strictly above the processor priority. The task priority can be written as a full byte or as a 4-bit class.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all three bitmaps are empty, the task priority and the processor priority read 0, and `intPending` and `eoiDone` are low.
- R2: When `enable` is high and `reqValid` is high for a vector that is not pending, `reqAccepted` is high in that cycle. From the next cycle the vector is pending, and its trigger bit equals `reqLevel` (1 = level, 0 = edge).
- R3: A request for a vector that is already pending gives `reqAccepted` low and leaves the pending bit set. A level repeat leaves the trigger bit unchanged. An edge repeat clears the trigger bit.
- R4: While `enable` is low, requests give `reqAccepted` low and leave no trace, and `intPending` is low.
- R5: `pprOut` equals the task priority when the task priority's bits [7:4] are greater than or equal to the class of the highest in-service vector (0 when nothing is in service). Otherwise it equals that vector with bits [3:0] cleared.
- R6: `intPending` is high exactly when `enable` is high, some vector is pending, and the highest pending vector with bits [3:0] cleared is strictly greater than `pprOut`. `intVector` is then that highest pending vector.
- R7: `ackValid` while `intPending` is high moves `intVector` from pending to in service at the clock edge.
- R8: `eoiValid` with at least one vector in service clears the highest in-service vector and its trigger bit. In the next cycle `eoiDone` pulses high for one cycle, with `eoiVector` holding that vector and `eoiLevel` holding its trigger bit from before the clear.
- R9: `eoiValid` with nothing in service changes no state and gives no `eoiDone` pulse.
- R10: `tprWrValid` loads the task priority with the 8-bit `tprWrData`. `cr8WrValid` loads bits [7:4] with `cr8WrData` and clears bits [3:0]. If both are high in the same cycle, the byte write wins.
- R11: `ackValid` while `intPending` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; requests are dropped and nothing is offered while low |
| reqValid | input | 1 | Interrupt request strobe |
| reqVector | input | 8 | Requested vector |
| reqLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered request |
| reqAccepted | output | 1 | Request recorded this cycle |
| intPending | output | 1 | A deliverable vector is offered |
| intVector | output | 8 | Offered vector |
| ackValid | input | 1 | Core takes the offered vector |
| eoiValid | input | 1 | End-of-interrupt command |
| eoiDone | output | 1 | One-cycle pulse after a retiring end-of-interrupt |
| eoiVector | output | 8 | Vector retired by the last end-of-interrupt |
| eoiLevel | output | 1 | Retired vector was level-triggered |
| tprWrValid | input | 1 | Full task priority write |
| tprWrData | input | 8 | Task priority byte |
| cr8WrValid | input | 1 | Class-only task priority write |
| cr8WrData | input | 4 | Class written to task priority bits [7:4] |
| tprOut | output | 8 | Current task priority |
| pprOut | output | 8 | Current processor priority |

## Verification
Directed sequences test the gating boundary: a task priority equal to the pending class blocks delivery, and one just below that class lets it through. They also test level and edge repeats of a pending vector, an end-of-interrupt with nothing in service, and an acknowledge with nothing offered. Each of these separates the strict comparison and the trigger-bit rules from an off-by-one or a missing guard. A long random phase then mixes requests over the whole vector range, nested acknowledges, end-of-interrupt commands and priority writes of both widths, with `enable` sometimes low. It compares every output against a bench model of the three bitmaps, so ordering faults in the searches and in simultaneous updates show up as wrong vectors or wrong trigger reports.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W   = 8;
  localparam int CLASS_W = 4;

  typedef struct packed {
    logic             pendSet;
    logic             tmrWr;
    logic             tmrVal;
    logic [VEC_W-1:0] reqVec;
    logic             ackWr;
    logic [VEC_W-1:0] ackVec;
    logic             eoiWr;
    logic [VEC_W-1:0] eoiVec;
    logic             tprWr;
    logic [VEC_W-1:0] tprVal;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_vec_search.sv
module irq_vec_search #(
  parameter int NUM_VEC   = 256,
  parameter int WORD_BITS = 32
) (
  input  logic [NUM_VEC-1:0]         bits,
  output logic                       found,
  output logic [$clog2(NUM_VEC)-1:0] index
);
  localparam int NUM_WORDS = NUM_VEC / WORD_BITS;
  localparam int BIT_W     = $clog2(WORD_BITS);
  localparam int WORD_W    = $clog2(NUM_WORDS);

  logic [NUM_WORDS-1:0] wordAny;
  logic [BIT_W-1:0]     wordTop [NUM_WORDS];

  // Per-word priority encoders, one per 32-bit slice
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign wordAny[w] = |bits[w*WORD_BITS +: WORD_BITS];
    always_comb begin
      wordTop[w] = '0;
      for (int b = 0; b < WORD_BITS; b++)
        if (bits[w*WORD_BITS + b]) wordTop[w] = BIT_W'(b);
    end
  end

  // Highest non-empty word selects the result
  always_comb begin
    found = 1'b0;
    index = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wordAny[w]) begin
        found = 1'b1;
        index = {WORD_W'(w), wordTop[w]};
      end
    end
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int WORD_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     st,
  input  logic [VEC_W-1:0] probeVec,
  output logic             probePending,
  output logic             hiIrrValid,
  output logic [VEC_W-1:0] hiIrr,
  output logic             hiIsrValid,
  output logic [VEC_W-1:0] hiIsr,
  output logic             tmrAtIsr,
  output logic [VEC_W-1:0] tpr
);
  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic [NUM_VEC-1:0] irrNext, isrNext, tmrNext;

  always_comb begin
    irrNext = irr;
    isrNext = isr;
    tmrNext = tmr;
    if (st.ackWr)   irrNext[st.ackVec] = 1'b0;
    if (st.pendSet) irrNext[st.reqVec] = 1'b1;
    if (st.eoiWr)   isrNext[st.eoiVec] = 1'b0;
    if (st.ackWr)   isrNext[st.ackVec] = 1'b1;
    if (st.eoiWr)   tmrNext[st.eoiVec] = 1'b0;
    if (st.tmrWr)   tmrNext[st.reqVec] = st.tmrVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
      tpr <= '0;
    end else begin
      irr <= irrNext;
      isr <= isrNext;
      tmr <= tmrNext;
      if (st.tprWr) tpr <= st.tprVal;
    end
  end

  irq_vec_search #(.NUM_VEC(NUM_VEC), .WORD_BITS(WORD_BITS)) u_irrSearch (
    .bits(irr), .found(hiIrrValid), .index(hiIrr));
  irq_vec_search #(.NUM_VEC(NUM_VEC), .WORD_BITS(WORD_BITS)) u_isrSearch (
    .bits(isr), .found(hiIsrValid), .index(hiIsr));

  assign probePending = irr[probeVec];
  assign tmrAtIsr     = tmr[hiIsr];

  // R7: acknowledged vector is in service and no longer pending
  assert_ack_moves_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.ackWr |=> (isr[$past(st.ackVec)] && !irr[$past(st.ackVec)]));

  // R8: retired vector leaves the in-service set and its trigger bit drops
  assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.eoiWr && !st.tmrWr) |=> (!isr[$past(st.eoiVec)] && !tmr[$past(st.eoiVec)]));

  // R2: an accepted vector is pending on the next cycle
  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    st.pendSet |=> irr[$past(st.reqVec)]);
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               reqValid,
  input  logic [VEC_W-1:0]   reqVector,
  input  logic               reqLevel,
  input  logic               ackValid,
  input  logic               eoiValid,
  input  logic               tprWrValid,
  input  logic [VEC_W-1:0]   tprWrData,
  input  logic               cr8WrValid,
  input  logic [CLASS_W-1:0] cr8WrData,
  input  logic               probePending,
  input  logic               hiIrrValid,
  input  logic [VEC_W-1:0]   hiIrr,
  input  logic               hiIsrValid,
  input  logic [VEC_W-1:0]   hiIsr,
  input  logic               tmrAtIsr,
  input  logic [VEC_W-1:0]   tpr,
  output ctrl_strobe_t       st,
  output logic               reqAccepted,
  output logic               intPending,
  output logic [VEC_W-1:0]   intVector,
  output logic [VEC_W-1:0]   ppr,
  output logic               eoiDone,
  output logic [VEC_W-1:0]   eoiVector,
  output logic               eoiLevel
);
  localparam int LOW_W = VEC_W - CLASS_W;

  logic [CLASS_W-1:0] isrClass;
  logic [VEC_W-1:0]   irrFloor;
  logic               reqLive;

  // Processor priority from task priority and highest in-service class
  always_comb begin
    isrClass = hiIsrValid ? hiIsr[VEC_W-1 -: CLASS_W] : '0;
    if (tpr[VEC_W-1 -: CLASS_W] >= isrClass) ppr = tpr;
    else                                     ppr = {isrClass, {LOW_W{1'b0}}};
  end

  assign irrFloor   = {hiIrr[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}};
  assign intPending = enable && hiIrrValid && (irrFloor > ppr);
  assign intVector  = hiIrr;

  assign reqLive     = reqValid && enable;
  assign reqAccepted = reqLive && !probePending;

  always_comb begin
    st         = '0;
    st.reqVec  = reqVector;
    st.pendSet = reqAccepted;
    st.tmrWr   = reqLive && (!probePending || !reqLevel);
    st.tmrVal  = reqLevel;
    st.ackWr   = ackValid && intPending;
    st.ackVec  = hiIrr;
    st.eoiWr   = eoiValid && hiIsrValid;
    st.eoiVec  = hiIsr;
    st.tprWr   = tprWrValid || cr8WrValid;
    st.tprVal  = tprWrValid ? tprWrData : {cr8WrData, {LOW_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eoiDone   <= 1'b0;
      eoiVector <= '0;
      eoiLevel  <= 1'b0;
    end else begin
      eoiDone <= st.eoiWr;
      if (st.eoiWr) begin
        eoiVector <= hiIsr;
        eoiLevel  <= tmrAtIsr;
      end
    end
  end

  // R5: processor priority never sits below the task priority
  assert_ppr_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    ppr >= tpr);

  // R4: a disabled controller neither accepts nor offers
  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!reqAccepted && !intPending));

  // R9: an end-of-interrupt with nothing in service produces no pulse
  assert_eoi_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (eoiValid && !hiIsrValid) |=> !eoiDone);

  // R10: a byte write lands in the task priority on the next cycle
  assert_tpr_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    tprWrValid |=> (tpr == $past(tprWrData)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int WORD_BITS = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         reqValid,
  input  logic [7:0]   reqVector,
  input  logic         reqLevel,
  output logic         reqAccepted,
  output logic         intPending,
  output logic [7:0]   intVector,
  input  logic         ackValid,
  input  logic         eoiValid,
  output logic         eoiDone,
  output logic [7:0]   eoiVector,
  output logic         eoiLevel,
  input  logic         tprWrValid,
  input  logic [7:0]   tprWrData,
  input  logic         cr8WrValid,
  input  logic [3:0]   cr8WrData,
  output logic [7:0]   tprOut,
  output logic [7:0]   pprOut
);
  ctrl_strobe_t     st;
  logic             probePending, hiIrrValid, hiIsrValid, tmrAtIsr;
  logic [VEC_W-1:0] hiIrr, hiIsr;

  irq_control u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .reqValid(reqValid), .reqVector(reqVector), .reqLevel(reqLevel),
    .ackValid(ackValid), .eoiValid(eoiValid),
    .tprWrValid(tprWrValid), .tprWrData(tprWrData),
    .cr8WrValid(cr8WrValid), .cr8WrData(cr8WrData),
    .probePending(probePending), .hiIrrValid(hiIrrValid), .hiIrr(hiIrr),
    .hiIsrValid(hiIsrValid), .hiIsr(hiIsr), .tmrAtIsr(tmrAtIsr), .tpr(tprOut),
    .st(st), .reqAccepted(reqAccepted), .intPending(intPending),
    .intVector(intVector), .ppr(pprOut),
    .eoiDone(eoiDone), .eoiVector(eoiVector), .eoiLevel(eoiLevel)
  );

  irq_datapath #(.NUM_VEC(NUM_VEC), .WORD_BITS(WORD_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .probeVec(reqVector),
    .probePending(probePending), .hiIrrValid(hiIrrValid), .hiIrr(hiIrr),
    .hiIsrValid(hiIsrValid), .hiIsr(hiIsr), .tmrAtIsr(tmrAtIsr), .tpr(tprOut)
  );
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic clk = 0, rstN = 0, enable = 0;
  logic reqValid = 0, reqLevel = 0, ackValid = 0, eoiValid = 0;
  logic tprWrValid = 0, cr8WrValid = 0;
  logic [7:0] reqVector = 0, tprWrData = 0;
  logic [3:0] cr8WrData = 0;
  logic reqAccepted, intPending, eoiDone, eoiLevel;
  logic [7:0] intVector, eoiVector, tprOut, pprOut;

  int tests = 0, fails = 0;
  logic [255:0] irrM = '0, isrM = '0, tmrM = '0;
  logic [7:0]   tprM = '0;
  logic         eDoneM = 0, eLvlM = 0;
  logic [7:0]   eVecM = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int hiOf(logic [255:0] b);
    for (int i = 255; i >= 0; i--) if (b[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] pprOf();
    int h = hiOf(isrM);
    logic [3:0] cls = (h < 0) ? 4'd0 : 4'(h >> 4);
    if (tprM[7:4] >= cls) return tprM;
    return {cls, 4'd0};
  endfunction

  function automatic logic pendOf();
    int h = hiOf(irrM);
    return enable && (h >= 0) && ((h & 8'hF0) > int'(pprOf()));
  endfunction

  // One clock: compare combinational outputs, advance model, compare registered ones
  task automatic cycle();
    logic acc, ackDo, eoiDo;
    int hp, hs;
    #1;
    hp = hiOf(irrM);
    hs = hiOf(isrM);
    chk("R10 tpr", tprOut, tprM);
    chk("R5 ppr", pprOut, pprOf());
    chk("R6 intPending", intPending, pendOf());
    if (pendOf()) chk("R6 intVector", intVector, hp);
    acc = reqValid && enable && !irrM[reqVector];
    if (reqValid) chk("R2 reqAccepted", reqAccepted, acc);
    ackDo = ackValid && pendOf();
    eoiDo = eoiValid && (hs >= 0);
    eDoneM = eoiDo;
    if (eoiDo) begin
      eVecM = 8'(hs);
      eLvlM = tmrM[hs];
      isrM[hs] = 1'b0;
      tmrM[hs] = 1'b0;
    end
    if (ackDo) begin
      irrM[hp] = 1'b0;
      isrM[hp] = 1'b1;
    end
    if (reqValid && enable) begin
      if (acc) tmrM[reqVector] = reqLevel;
      else if (!reqLevel) tmrM[reqVector] = 1'b0;
      if (acc) irrM[reqVector] = 1'b1;
    end
    if (tprWrValid) tprM = tprWrData;
    else if (cr8WrValid) tprM = {cr8WrData, 4'd0};
    @(posedge clk);
    @(negedge clk);
    chk("R8 R9 eoiDone", eoiDone, eDoneM);
    if (eDoneM) begin
      chk("R8 eoiVector", eoiVector, eVecM);
      chk("R8 eoiLevel", eoiLevel, eLvlM);
    end
    reqValid = 0; ackValid = 0; eoiValid = 0; tprWrValid = 0; cr8WrValid = 0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk("R1 intPending", intPending, 0);
    chk("R1 ppr", pprOut, 0);
    chk("R1 tpr", tprOut, 0);
    chk("R1 eoiDone", eoiDone, 0);

    // R4: disabled request leaves no trace
    reqValid = 1; reqVector = 8'h80; reqLevel = 1;
    #1 chk("R4 reqAccepted", reqAccepted, 0);
    cycle();
    enable = 1;
    #1 chk("R4 no pending after enable", intPending, 0);
    cycle();

    // R2: level request is offered
    reqValid = 1; reqVector = 8'h40; reqLevel = 1;
    #1 chk("R2 accept", reqAccepted, 1);
    cycle();
    #1 chk("R2 offered", intPending, 1);
    chk("R2 vector", intVector, 8'h40);
    // R3: level repeat rejected
    reqValid = 1; reqVector = 8'h40; reqLevel = 1;
    #1 chk("R3 repeat rejected", reqAccepted, 0);
    cycle();

    // R6: strict class boundary
    tprWrValid = 1; tprWrData = 8'h40; cycle();
    #1 chk("R6 equal class blocks", intPending, 0);
    tprWrValid = 1; tprWrData = 8'h3F; cycle();
    #1 chk("R6 lower floor passes", intPending, 1);
    cr8WrValid = 1; cr8WrData = 4'h5; cycle();
    #1 chk("R10 class write", tprOut, 8'h50);
    tprWrValid = 1; tprWrData = 8'h21; cr8WrValid = 1; cr8WrData = 4'h7; cycle();
    #1 chk("R10 byte write wins", tprOut, 8'h21);

    // R7: acknowledge, then R5 class from in-service vector
    ackValid = 1; cycle();
    #1 chk("R7 nothing left", intPending, 0);
    chk("R5 ppr from isr", pprOut, 8'h40);
    // R11: acknowledge with nothing offered
    ackValid = 1; cycle();
    #1 chk("R11 ppr unchanged", pprOut, 8'h40);

    // R8: level EOI
    eoiValid = 1; cycle();
    chk("R8 level report", eoiLevel, 1);
    // R9: EOI with nothing in service
    eoiValid = 1; cycle();
    chk("R9 no pulse", eoiDone, 0);

    // R3: edge repeat clears the trigger bit
    tprWrValid = 1; tprWrData = 8'h00; cycle();
    reqValid = 1; reqVector = 8'h60; reqLevel = 1; cycle();
    reqValid = 1; reqVector = 8'h60; reqLevel = 0;
    #1 chk("R3 edge repeat rejected", reqAccepted, 0);
    cycle();
    ackValid = 1; cycle();
    eoiValid = 1; cycle();
    chk("R3 trigger cleared", eoiLevel, 0);
    chk("R3 vector", eoiVector, 8'h60);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      enable     = ($urandom_range(0, 19) != 0);
      reqValid   = ($urandom_range(0, 9) < 4);
      reqVector  = 8'($urandom_range(0, 255));
      reqLevel   = 1'($urandom_range(0, 1));
      ackValid   = ($urandom_range(0, 9) < 3);
      eoiValid   = ($urandom_range(0, 9) < 2);
      tprWrValid = ($urandom_range(0, 29) == 0);
      tprWrData  = 8'($urandom_range(0, 8'h6F));
      cr8WrValid = ($urandom_range(0, 29) == 0);
      cr8WrData  = 4'($urandom_range(0, 6));
      cycle();
    end
    finishRun();
  end
endmodule